// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches recent virtual-to-physical page translations for a processor's memory path. A lookup presents a virtual address with its access type (read or write, kernel or user). Every stored entry is compared with the page number at once. On a match with sufficient permissions, the physical address comes out in the same cycle: the stored physical page number followed by the untouched 12-bit page offset. A match whose permissions forbid the access gives a protection fault instead. No match gives a miss, so that an external page table walker can fetch the translation.

The walker writes its result through the refill port. A new tag replaces the entry under a round-robin (first-in, first-out) pointer. A tag that is already stored is overwritten in place. The flush input empties the whole buffer in one cycle. Each entry keeps readable, writable, user-accessible and dirty flags. The first successful write to a clean page sets its dirty flag, and the dirty flag of the entry that hits is reported beside the translation.

Both data paths use a valid/ready pair. A lookup is accepted in any cycle where `lkp_valid_i` and `lkp_ready_o` are both high, and it is answered in that same cycle. A refill is taken at the clock edge ending a cycle where `fill_valid_i` and `fill_ready_o` are both high. Both ready outputs are low only while `flush_i` is high. A requester that sees ready low must hold its request and present it again.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, and in every cycle after a flush cycle (until a new refill), every accepted lookup misses. Flush also returns the replacement pointer to entry 0.
- R2: An accepted lookup that matches a valid entry with sufficient permission raises `lkp_hit_o` in the same cycle. In that cycle `lkp_paddr_o` is the entry's physical page number in bits [PA_W-1:12], and the lookup address bits [11:0] sit unchanged below it.
- R3: An accepted lookup with no valid matching entry raises `lkp_miss_o` alone, and `lkp_paddr_o` is 0. Exactly one of hit, miss and fault is high for each accepted lookup.
- R4: A matching entry raises `lkp_fault_o` (with hit low and `lkp_paddr_o` 0) when the access is refused. An access is refused when it is a write (`lkp_write_i`=1) to an entry whose writable flag is 0, or a read (`lkp_write_i`=0) to an entry whose readable flag is 0, or a user access (`lkp_user_i`=1) to an entry whose user flag is 0. Kernel accesses ignore the user flag.
- R5: On a hit, `lkp_dirty_o` shows the entry's dirty flag as stored before this cycle. A write hit sets that flag at the clock edge.
- R6: A refill whose tag is not stored writes the entry under the replacement pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0, so the oldest entry is evicted first.
- R7: A refill whose tag matches a valid entry overwrites that entry (the lowest-indexed one) and leaves the replacement pointer unchanged.
- R8: When a write hit and an accepted refill target the same entry in one cycle, the refill contents win, including its dirty flag.
- R9: `lkp_ready_o` and `fill_ready_o` are low exactly when `flush_i` is high. A refill offered while flushing is not stored. Hit, miss and fault are all low in any cycle without an accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| lkp_valid_i | input | 1 | Lookup request present |
| lkp_ready_o | output | 1 | Lookup can be accepted |
| lkp_vaddr_i | input | VA_W | Virtual address to translate |
| lkp_write_i | input | 1 | 1 = write access, 0 = read access |
| lkp_user_i | input | 1 | 1 = user-mode access, 0 = kernel |
| lkp_hit_o | output | 1 | Translation found and permitted |
| lkp_miss_o | output | 1 | No valid entry for this page |
| lkp_fault_o | output | 1 | Entry found but access refused |
| lkp_paddr_o | output | PA_W | Physical address on hit, else 0 |
| lkp_dirty_o | output | 1 | Dirty flag of the hit entry |
| fill_valid_i | input | 1 | Refill request present |
| fill_ready_o | output | 1 | Refill can be accepted |
| fill_vpn_i | input | VA_W-12 | Virtual page tag to store |
| fill_ppn_i | input | PA_W-12 | Physical page number to store |
| fill_rd_i | input | 1 | Readable flag |
| fill_wr_i | input | 1 | Writable flag |
| fill_usr_i | input | 1 | User-accessible flag |
| fill_dirty_i | input | 1 | Initial dirty flag |

## Verification
The collision that matters is a write hit that wants to set an entry's dirty flag in the same cycle that a refill rewrites that same entry. A directed case provokes it by re-filling the tag being written with a clean dirty flag. A follow-up read must then show a clear dirty flag and the new physical page. A second same-cycle pair, flush against refill, is provoked both in a directed step and at random. That pair is judged by confirming that the refilled tag still misses afterwards. The random phase draws tags from a pool only slightly larger than the buffer, so write hits meet FIFO evictions of their own entry, and a bench model decides each expected verdict.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Per-entry access flags
  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
    logic dirty;
  } perm_t;

  // Access is allowed when the type flag matches and user mode is granted
  function automatic logic perm_ok(perm_t p, logic is_write, logic is_user);
    logic type_ok;
    type_ok = is_write ? p.wr : p.rd;
    return type_ok && (!is_user || p.usr);
  endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare with lowest-index priority select.
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             valid_i [ENTRIES],
  input  logic [VPN_W-1:0] tags_i  [ENTRIES],
  input  logic [VPN_W-1:0] key_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [ENTRIES-1:0] eq_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq_vec[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |eq_vec;

endmodule

// File: rtl/tlb_fifo_ptr.sv
// Round-robin victim pointer with wrap at ENTRIES-1.
module tlb_fifo_ptr #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
    end else if (clr_i) begin
      ptr_o <= '0;
    end else if (adv_i) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_entry_array.sv
// Entry storage: flush clears valid, refill writes one slot, a write hit sets dirty.
module tlb_entry_array #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic                 fill_en_i,
  input  logic [IDX_W-1:0]     fill_idx_i,
  input  logic [VPN_W-1:0]     fill_vpn_i,
  input  logic [PPN_W-1:0]     fill_ppn_i,
  input  tlb_pkg::perm_t       fill_perm_i,
  input  logic                 dset_en_i,
  input  logic [IDX_W-1:0]     dset_idx_i,
  output logic                 valid_o [ENTRIES],
  output logic [VPN_W-1:0]     vpn_o   [ENTRIES],
  output logic [PPN_W-1:0]     ppn_o   [ENTRIES],
  output tlb_pkg::perm_t       perm_o  [ENTRIES]
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic           v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    tlb_pkg::perm_t perm_q;
    logic           fill_here;
    logic           dset_here;

    assign fill_here = fill_en_i && (fill_idx_i == IDX_W'(g));
    assign dset_here = dset_en_i && (dset_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        vpn_q  <= '0;
        ppn_q  <= '0;
        perm_q <= '0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (fill_here) begin
        // refill wins over a same-cycle dirty update
        v_q    <= 1'b1;
        vpn_q  <= fill_vpn_i;
        ppn_q  <= fill_ppn_i;
        perm_q <= fill_perm_i;
      end else if (dset_here) begin
        perm_q.dirty <= 1'b1;
      end
    end

    assign valid_o[g] = v_q;
    assign vpn_o[g]   = vpn_q;
    assign ppn_o[g]   = ppn_q;
    assign perm_o[g]  = perm_q;
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             lkp_valid_i,
  output logic             lkp_ready_o,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  input  logic             lkp_write_i,
  input  logic             lkp_user_i,
  output logic             lkp_hit_o,
  output logic             lkp_miss_o,
  output logic             lkp_fault_o,
  output logic [PA_W-1:0]  lkp_paddr_o,
  output logic             lkp_dirty_o,
  input  logic             fill_valid_i,
  output logic             fill_ready_o,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_usr_i,
  input  logic             fill_dirty_i
);

  logic             ent_valid [ENTRIES];
  logic [VPN_W-1:0] ent_vpn   [ENTRIES];
  logic [PPN_W-1:0] ent_ppn   [ENTRIES];
  tlb_pkg::perm_t   ent_perm  [ENTRIES];

  logic             lkp_any;
  logic [IDX_W-1:0] lkp_idx;
  logic             fill_any;
  logic [IDX_W-1:0] fill_hit_idx;
  logic [IDX_W-1:0] victim_ptr;

  logic             lkp_accept;
  logic             access_ok;
  tlb_pkg::perm_t   sel_perm;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic             dset_en;
  tlb_pkg::perm_t   fill_perm;

  // Handshake: flush blocks both request paths for one cycle
  assign lkp_ready_o  = !flush_i;
  assign fill_ready_o = !flush_i;
  assign lkp_accept   = lkp_valid_i && lkp_ready_o;
  assign fill_en      = fill_valid_i && fill_ready_o;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lkp_match (
    .valid_i (ent_valid),
    .tags_i  (ent_vpn),
    .key_i   (lkp_vaddr_i[VA_W-1:OFS_W]),
    .any_o   (lkp_any),
    .idx_o   (lkp_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .valid_i (ent_valid),
    .tags_i  (ent_vpn),
    .key_i   (fill_vpn_i),
    .any_o   (fill_any),
    .idx_o   (fill_hit_idx)
  );

  // Verdict for the lookup
  assign sel_perm  = ent_perm[lkp_idx];
  assign access_ok = tlb_pkg::perm_ok(sel_perm, lkp_write_i, lkp_user_i);

  assign lkp_hit_o   = lkp_accept && lkp_any && access_ok;
  assign lkp_fault_o = lkp_accept && lkp_any && !access_ok;
  assign lkp_miss_o  = lkp_accept && !lkp_any;
  assign lkp_paddr_o = lkp_hit_o ? {ent_ppn[lkp_idx], lkp_vaddr_i[OFS_W-1:0]} : '0;
  assign lkp_dirty_o = lkp_hit_o && sel_perm.dirty;

  // First write to a clean page marks it dirty
  assign dset_en = lkp_hit_o && lkp_write_i && !sel_perm.dirty;

  // Refill target: existing tag in place, else FIFO victim
  assign fill_idx = fill_any ? fill_hit_idx : victim_ptr;
  always_comb begin
    fill_perm.rd    = fill_rd_i;
    fill_perm.wr    = fill_wr_i;
    fill_perm.usr   = fill_usr_i;
    fill_perm.dirty = fill_dirty_i;
  end

  tlb_fifo_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (flush_i),
    .adv_i (fill_en && !fill_any),
    .ptr_o (victim_ptr)
  );

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .fill_en_i   (fill_en),
    .fill_idx_i  (fill_idx),
    .fill_vpn_i  (fill_vpn_i),
    .fill_ppn_i  (fill_ppn_i),
    .fill_perm_i (fill_perm),
    .dset_en_i   (dset_en),
    .dset_idx_i  (lkp_idx),
    .valid_o     (ent_valid),
    .vpn_o       (ent_vpn),
    .ppn_o       (ent_ppn),
    .perm_o      (ent_perm)
  );

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush_i,
  input logic                  lkp_valid_i,
  input logic                  lkp_ready_o,
  input logic [VA_W-1:0]       lkp_vaddr_i,
  input logic                  lkp_write_i,
  input logic                  lkp_hit_o,
  input logic                  lkp_miss_o,
  input logic                  lkp_fault_o,
  input logic [PA_W-1:0]       lkp_paddr_o,
  input logic                  lkp_dirty_o,
  input logic                  fill_valid_i,
  input logic                  fill_ready_o,
  input logic [VA_W-OFS_W-1:0] fill_vpn_i
);

  logic acc;
  assign acc = lkp_valid_i && lkp_ready_o;

  p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ($countones({lkp_hit_o, lkp_miss_o, lkp_fault_o}) == 1));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> !(lkp_hit_o || lkp_miss_o || lkp_fault_o));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit_o |-> (lkp_paddr_o[OFS_W-1:0] == lkp_vaddr_i[OFS_W-1:0]));

  p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_fault_o |-> (lkp_paddr_o == '0));

  p_flush_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !(lkp_hit_o || lkp_fault_o));

  p_fill_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && fill_ready_o) |=>
      (!(acc && lkp_vaddr_i[VA_W-1:OFS_W] == $past(fill_vpn_i)) || !lkp_miss_o));

  p_write_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_hit_o && lkp_write_i && !flush_i && !fill_valid_i) |=>
      (!(lkp_hit_o && lkp_vaddr_i[VA_W-1:OFS_W] == $past(lkp_vaddr_i[VA_W-1:OFS_W]))
       || lkp_dirty_o));

endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_ready_o  (lkp_ready_o),
  .lkp_vaddr_i  (lkp_vaddr_i),
  .lkp_write_i  (lkp_write_i),
  .lkp_hit_o    (lkp_hit_o),
  .lkp_miss_o   (lkp_miss_o),
  .lkp_fault_o  (lkp_fault_o),
  .lkp_paddr_o  (lkp_paddr_o),
  .lkp_dirty_o  (lkp_dirty_o),
  .fill_valid_i (fill_valid_i),
  .fill_ready_o (fill_ready_o),
  .fill_vpn_i   (fill_vpn_i)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

  localparam int N     = 32;
  localparam int VA_W  = 32;
  localparam int PA_W  = 32;
  localparam int OFS_W = 12;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0;
  logic lkp_valid_i = 1'b0;
  logic lkp_ready_o;
  logic [VA_W-1:0] lkp_vaddr_i = '0;
  logic lkp_write_i = 1'b0;
  logic lkp_user_i = 1'b0;
  logic lkp_hit_o, lkp_miss_o, lkp_fault_o, lkp_dirty_o;
  logic [PA_W-1:0] lkp_paddr_o;
  logic fill_valid_i = 1'b0;
  logic fill_ready_o;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [PPN_W-1:0] fill_ppn_i = '0;
  logic fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_usr_i = 1'b0, fill_dirty_i = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tlb_xlate #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lkp_valid_i(lkp_valid_i), .lkp_ready_o(lkp_ready_o), .lkp_vaddr_i(lkp_vaddr_i),
    .lkp_write_i(lkp_write_i), .lkp_user_i(lkp_user_i),
    .lkp_hit_o(lkp_hit_o), .lkp_miss_o(lkp_miss_o), .lkp_fault_o(lkp_fault_o),
    .lkp_paddr_o(lkp_paddr_o), .lkp_dirty_o(lkp_dirty_o),
    .fill_valid_i(fill_valid_i), .fill_ready_o(fill_ready_o),
    .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i), .fill_usr_i(fill_usr_i),
    .fill_dirty_i(fill_dirty_i)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model
  bit             m_valid [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [PPN_W-1:0] m_ppn [N];
  bit m_rd [N], m_wr [N], m_usr [N], m_dirty [N];
  int m_ptr = 0;

  int e_k;
  bit e_wset;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_find(logic [VPN_W-1:0] v);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic idle();
    flush_i = 0; lkp_valid_i = 0; lkp_write_i = 0; lkp_user_i = 0; fill_valid_i = 0;
  endtask

  task automatic set_lkp(logic [VPN_W-1:0] v, logic [OFS_W-1:0] ofs, bit w, bit u);
    lkp_valid_i = 1; lkp_vaddr_i = {v, ofs}; lkp_write_i = w; lkp_user_i = u;
  endtask

  task automatic set_fill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, bit r, bit w, bit u, bit d);
    fill_valid_i = 1; fill_vpn_i = v; fill_ppn_i = p;
    fill_rd_i = r; fill_wr_i = w; fill_usr_i = u; fill_dirty_i = d;
  endtask

  // Compare outputs against the model for current inputs
  task automatic eval();
    bit acc, ok, eh, ef, em;
    logic [PA_W-1:0] epa;
    #1;
    acc = lkp_valid_i && !flush_i;
    e_k = m_find(lkp_vaddr_i[VA_W-1:OFS_W]);
    ok = 0;
    if (e_k >= 0) ok = (lkp_write_i ? m_wr[e_k] : m_rd[e_k]) && (!lkp_user_i || m_usr[e_k]);
    eh = acc && e_k >= 0 && ok;
    ef = acc && e_k >= 0 && !ok;
    em = acc && e_k < 0;
    epa = eh ? {m_ppn[e_k], lkp_vaddr_i[OFS_W-1:0]} : '0;
    e_wset = eh && lkp_write_i;
    chk("R9 lkp_ready", lkp_ready_o, !flush_i);
    chk("R9 fill_ready", fill_ready_o, !flush_i);
    chk("R2 hit", lkp_hit_o, eh);
    chk("R3 miss", lkp_miss_o, em);
    chk("R4 fault", lkp_fault_o, ef);
    chk("R2 paddr", lkp_paddr_o, epa);
    chk("R5 dirty", lkp_dirty_o, eh && m_dirty[e_k]);
  endtask

  task automatic tick();
    int j;
    @(posedge clk);
    if (flush_i) begin
      for (int i = 0; i < N; i++) m_valid[i] = 0;
      m_ptr = 0;
    end else begin
      if (e_wset) m_dirty[e_k] = 1;
      if (fill_valid_i) begin
        j = m_find(fill_vpn_i);
        if (j < 0) begin j = m_ptr; m_ptr = (m_ptr + 1) % N; end
        m_valid[j] = 1; m_vpn[j] = fill_vpn_i; m_ppn[j] = fill_ppn_i;
        m_rd[j] = fill_rd_i; m_wr[j] = fill_wr_i; m_usr[j] = fill_usr_i; m_dirty[j] = fill_dirty_i;
      end
    end
    @(negedge clk);
  endtask

  task automatic step();
    eval();
    tick();
    idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, lookup misses
    set_lkp(20'h00055, 12'h123, 0, 0);
    eval();
    chk("R1 miss after reset", lkp_miss_o, 1'b1);
    tick(); idle();

    // R2: fill then read hit with offset passthrough
    set_fill(20'h00055, 20'hABCDE, 1, 1, 1, 0); step();
    set_lkp(20'h00055, 12'hFED, 0, 1);
    eval();
    chk("R2 paddr", lkp_paddr_o, 32'hABCDEFED);
    tick(); idle();

    // R4: read-only kernel page: user read faults, kernel write faults
    set_fill(20'h00066, 20'h11111, 1, 0, 0, 0); step();
    set_lkp(20'h00066, 12'h004, 0, 1); eval();
    chk("R4 user to kernel page", lkp_fault_o, 1'b1); tick(); idle();
    set_lkp(20'h00066, 12'h004, 1, 0); eval();
    chk("R4 write to read-only", lkp_fault_o, 1'b1); tick(); idle();
    set_lkp(20'h00066, 12'h004, 0, 0); eval();
    chk("R4 kernel read allowed", lkp_hit_o, 1'b1); tick(); idle();

    // R5: write hit sets dirty, visible on next hit
    set_lkp(20'h00055, 12'h000, 1, 0); eval();
    chk("R5 dirty before write", lkp_dirty_o, 1'b0); tick(); idle();
    set_lkp(20'h00055, 12'h000, 0, 0); eval();
    chk("R5 dirty after write", lkp_dirty_o, 1'b1); tick(); idle();

    // R8: write hit and refill of same entry in one cycle, refill wins
    set_fill(20'h00077, 20'h22222, 1, 1, 0, 0); step();
    set_lkp(20'h00077, 12'h010, 1, 0);
    set_fill(20'h00077, 20'h33333, 1, 1, 0, 0);
    step();
    set_lkp(20'h00077, 12'h010, 0, 0); eval();
    chk("R8 refill dirty wins", lkp_dirty_o, 1'b0);
    chk("R8 refill ppn wins", lkp_paddr_o, 32'h33333010);
    tick(); idle();

    // R9: flush with simultaneous refill: refill dropped; R1 after flush
    flush_i = 1; set_fill(20'h00088, 20'h44444, 1, 1, 1, 0); step();
    set_lkp(20'h00088, 12'h0, 0, 0); eval();
    chk("R9 fill dropped during flush", lkp_miss_o, 1'b1); tick(); idle();
    set_lkp(20'h00055, 12'h0, 0, 0); eval();
    chk("R1 miss after flush", lkp_miss_o, 1'b1); tick(); idle();

    // R6: fill N+1 distinct tags; first one evicted, second kept
    for (int i = 0; i <= N; i++) begin
      set_fill(20'h00200 + 20'(i), 20'h50000 + 20'(i), 1, 1, 1, 0); step();
    end
    set_lkp(20'h00200, 12'h0, 0, 0); eval();
    chk("R6 oldest evicted", lkp_miss_o, 1'b1); tick(); idle();
    set_lkp(20'h00201, 12'h0, 0, 0); eval();
    chk("R6 second kept", lkp_hit_o, 1'b1); tick(); idle();

    // R7: refill existing tag in place, pointer unchanged (next new tag evicts 0x201)
    set_fill(20'h00205, 20'h7AAAA, 1, 1, 1, 0); step();
    set_lkp(20'h00205, 12'h3, 0, 0); eval();
    chk("R7 in-place overwrite", lkp_paddr_o, 32'h7AAAA003); tick(); idle();
    set_fill(20'h00300, 20'h60000, 1, 1, 1, 0); step();
    set_lkp(20'h00201, 12'h0, 0, 0); eval();
    chk("R7 pointer not advanced", lkp_miss_o, 1'b1); tick(); idle();
    set_lkp(20'h00202, 12'h0, 0, 0); eval();
    chk("R7 next entry kept", lkp_hit_o, 1'b1); tick(); idle();

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      flush_i = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 9) < 8)
        set_lkp(20'h00400 + 20'($urandom_range(0, 39)), 12'($urandom()),
                1'($urandom()), 1'($urandom()));
      if ($urandom_range(0, 9) < 3)
        set_fill(20'h00400 + 20'($urandom_range(0, 39)), 20'($urandom()),
                 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule